// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block produces the serial clock waveform that an I2C master drives. The module clock first passes through a programmable prescaler; the ticks it produces then time a low phase and a high phase, one after the other. Each phase lasts its programmed count plus a fixed extension `d` that depends on the prescaler setting. For every phase end the block gives the bit engine a single-cycle strobe, so the engine can shift data and sample the line at the correct points.

A run input stands for the controller's module-enable bit. While run is low the timer stays idle and takes a copy of the three divider inputs. Once run goes high it starts with a full low phase and uses the copied values for as long as it runs. Changes on the divider inputs during a run have no effect. An optional window check reports whether the prescaled tick rate, for the module clock frequency given as a parameter, lies inside the allowed band.

Top module: `i2c_scl_timer`

## Requirements
- R1: While rst_n is low, or in any cycle in which the block is idle (run was low at the previous clock edge), scl_en is 0, scl_level is 1, and end_low and end_high are both 0.
- R2: In the first cycle after run is sampled high, scl_en is 1 and scl_level is 0. The low phase lasts (psc_in+1)*(low_in+d) module clock cycles.
- R3: Right after the low phase, scl_level is 1 for (psc_in+1)*(high_in+d) cycles. After that the low and high phases keep alternating.
- R4: The extension d is 7 when the held prescaler value is 0, 6 when it is 1, and 5 when it is 2 or more.
- R5: A count value of 0 is used as is, so that phase lasts exactly d prescaled ticks.
- R6: end_low is high for exactly one cycle per low phase, in its last cycle. end_high is high for exactly one cycle per high phase, in its last cycle. The two strobes are never high together.
- R7: The divider inputs are captured only while the block is idle. Changing them while it runs does not alter the current or any later phase of that run.
- R8: When run is dropped the block is idle in the next cycle. When run is raised again, timing restarts with a full low phase that uses the values captured during the idle period.
- R9: range_ok is 1 exactly when MIN_HZ*(p+1) <= CLK_HZ <= MAX_HZ*(p+1), where p is the held prescaler value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Module enable; low holds the timer idle and opens config capture |
| psc_in | input | PSC_W | Prescaler value; ticks occur every psc_in+1 clocks |
| low_in | input | CNT_W | Low-phase count in prescaled ticks, before extension |
| high_in | input | CNT_W | High-phase count in prescaled ticks, before extension |
| scl_en | output | 1 | High while the timer is running |
| scl_level | output | 1 | Wanted SCL level; 1 when idle |
| end_low | output | 1 | One-cycle strobe in the last cycle of a low phase |
| end_high | output | 1 | One-cycle strobe in the last cycle of a high phase |
| range_ok | output | 1 | Held prescaler gives a tick rate inside the allowed band |

## Verification
The risky coincidence is a phase-end strobe landing in the same cycle in which run is dropped. To provoke it, the bench waits for end_low with the shortest configuration and lowers run at that very cycle. The next cycle must then be idle, with the line released high and no strobe. When run is raised again, the bench expects a full low phase and not a leftover. A second collision is a divider change arriving together with the start of a run. The bench writes new values in the first running cycle and expects both phases to keep the values captured before the run.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  // Extension added to every phase, chosen by the prescaler setting.
  function automatic int unsigned phase_offset(input int unsigned psc);
    if (psc == 0)      return 7;
    else if (psc == 1) return 6;
    else               return 5;
  endfunction

  // Ticks that one phase lasts: the programmed count plus the extension.
  function automatic int unsigned phase_ticks(input int unsigned cnt,
                                              input int unsigned psc);
    return cnt + phase_offset(psc);
  endfunction

  // True when clk_hz/(psc+1) lies inside [lo_hz, hi_hz]. No division is needed.
  function automatic logic in_window(input longint unsigned clk_hz,
                                     input longint unsigned lo_hz,
                                     input longint unsigned hi_hz,
                                     input int unsigned     psc);
    longint unsigned div;
    div = longint'(psc) + 64'd1;
    return (lo_hz * div <= clk_hz) && (hi_hz * div >= clk_hz);
  endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      psc_q  <= psc_in;
      low_q  <= low_in;
      high_q <= high_in;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);

  logic [PSC_W-1:0] cnt_q;

  assign tick = !clear && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timer_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_low,
  input  logic [LEN_W-1:0] len_high,
  output scl_phase_e       phase,
  output logic             end_low,
  output logic             end_high
);

  scl_phase_e       phase_q;
  logic [LEN_W-1:0] tcnt_q;
  logic [LEN_W-1:0] cur_len;
  logic             last_tick;
  logic             phase_done;

  assign cur_len    = (phase_q == PH_LOW) ? len_low : len_high;
  assign last_tick  = (tcnt_q == cur_len - 1'b1);
  assign phase_done = !clear && tick && last_tick;
  assign end_low    = phase_done && (phase_q == PH_LOW);
  assign end_high   = phase_done && (phase_q == PH_HIGH);
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      tcnt_q  <= '0;
    end else if (clear) begin
      phase_q <= PH_LOW;
      tcnt_q  <= '0;
    end else if (tick) begin
      if (last_tick) begin
        tcnt_q  <= '0;
        phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      end else begin
        tcnt_q  <= tcnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_range_chk.sv
module scl_range_chk
  import scl_timer_pkg::*;
#(
  parameter int          PSC_W  = 8,
  parameter longint      CLK_HZ = 50_000_000,
  parameter longint      MIN_HZ = 7_000_000,
  parameter longint      MAX_HZ = 12_000_000
) (
  input  logic [PSC_W-1:0] psc,
  output logic             ok
);

  assign ok = in_window(CLK_HZ, MIN_HZ, MAX_HZ, 32'(psc));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import scl_timer_pkg::*;
#(
  parameter int     PSC_W  = 8,
  parameter int     CNT_W  = 16,
  parameter longint CLK_HZ = 50_000_000,
  parameter longint MIN_HZ = 7_000_000,
  parameter longint MAX_HZ = 12_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic             scl_en,
  output logic             scl_level,
  output logic             end_low,
  output logic             end_high,
  output logic             range_ok
);

  localparam int LEN_W = CNT_W + 1;

  logic             active_q;
  logic             idle;
  logic [PSC_W-1:0] cfg_psc;
  logic [CNT_W-1:0] cfg_low;
  logic [CNT_W-1:0] cfg_high;
  logic [LEN_W-1:0] len_low;
  logic [LEN_W-1:0] len_high;
  logic             tick;
  scl_phase_e       phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= run;
  end

  assign idle = !active_q;

  scl_cfg_hold #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (idle),
    .psc_in  (psc_in),
    .low_in  (low_in),
    .high_in (high_in),
    .psc_q   (cfg_psc),
    .low_q   (cfg_low),
    .high_q  (cfg_high)
  );

  assign len_low  = LEN_W'(phase_ticks(32'(cfg_low),  32'(cfg_psc)));
  assign len_high = LEN_W'(phase_ticks(32'(cfg_high), 32'(cfg_psc)));

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (idle),
    .limit (cfg_psc),
    .tick  (tick)
  );

  scl_phase_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (idle),
    .tick     (tick),
    .len_low  (len_low),
    .len_high (len_high),
    .phase    (phase),
    .end_low  (end_low),
    .end_high (end_high)
  );

  scl_range_chk #(
    .PSC_W(PSC_W), .CLK_HZ(CLK_HZ), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ)
  ) u_rng (
    .psc (cfg_psc),
    .ok  (range_ok)
  );

  assign scl_en    = active_q;
  assign scl_level = active_q ? (phase == PH_HIGH) : 1'b1;

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_en,
  input logic             scl_level,
  input logic             end_low,
  input logic             end_high,
  input logic             tick,
  input logic [PSC_W-1:0] cfg_psc,
  input logic [CNT_W-1:0] cfg_low,
  input logic [CNT_W-1:0] cfg_high
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_en |-> (scl_level && !end_low && !end_high));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_en) |-> !scl_level);

  // R3: while running, the level changes only after a phase-end strobe
  assert_flip_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_en && $past(scl_en) && (scl_level != $past(scl_level)))
      |-> $past(end_low || end_high));

  assert_low_end_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_low |=> scl_level);

  assert_high_end_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_high |=> (!scl_level || !scl_en));

  assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_low || end_high) |-> (tick && !(end_low && end_high)));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_en && $past(scl_en))
      |-> ($stable(cfg_psc) && $stable(cfg_low) && $stable(cfg_high)));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_en    (scl_en),
  .scl_level (scl_level),
  .end_low   (end_low),
  .end_high  (end_high),
  .tick      (tick),
  .cfg_psc   (cfg_psc),
  .cfg_low   (cfg_low),
  .cfg_high  (cfg_high)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

  localparam int     PSC_W  = 8;
  localparam int     CNT_W  = 16;
  localparam longint CLK_HZ = 50_000_000;
  localparam int     NVEC   = 7;

  // Each entry: {psc, low count, high count}
  localparam logic [PSC_W+2*CNT_W-1:0] VEC [NVEC] = '{
    {8'd0, 16'd0,  16'd0},
    {8'd1, 16'd3,  16'd2},
    {8'd2, 16'd1,  16'd4},
    {8'd4, 16'd10, 16'd5},
    {8'd0, 16'd20, 16'd0},
    {8'd9, 16'd2,  16'd3},
    {8'd6, 16'd0,  16'd7}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [PSC_W-1:0] psc_in = '0;
  logic [CNT_W-1:0] low_in = '0;
  logic [CNT_W-1:0] high_in = '0;
  logic             scl_en, scl_level, end_low, end_high, range_ok;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  i2c_scl_timer #(.PSC_W(PSC_W), .CNT_W(CNT_W), .CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .psc_in(psc_in), .low_in(low_in),
    .high_in(high_in), .scl_en(scl_en), .scl_level(scl_level),
    .end_low(end_low), .end_high(end_high), .range_ok(range_ok)
  );

  function automatic int exp_cycles(input int p, input int c);
    int d;
    d = (p == 0) ? 7 : ((p == 1) ? 6 : 5);
    return (p + 1) * (c + d);
  endfunction

  function automatic int exp_range(input int p);
    longint lo, hi;
    lo = 64'd7_000_000 * longint'(p + 1);
    hi = 64'd12_000_000 * longint'(p + 1);
    return ((lo <= CLK_HZ) && (hi >= CLK_HZ)) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Measures one low phase and one high phase, starting from the current cycle.
  task automatic measure(output int lo, output int hi, output bit sok);
    int s_lo = 0, s_hi = 0, p_lo = -1, p_hi = -1;
    lo = 0; hi = 0; sok = 1'b1;
    while (scl_en && !scl_level && lo < 5000) begin
      if (end_low)  begin s_lo++; p_lo = lo; end
      if (end_high) sok = 1'b0;
      lo++;
      @(negedge clk);
    end
    while (scl_en && scl_level && hi < 5000) begin
      if (end_high) begin s_hi++; p_hi = hi; end
      if (end_low)  sok = 1'b0;
      hi++;
      @(negedge clk);
    end
    if (s_lo != 1 || p_lo != lo - 1 || s_hi != 1 || p_hi != hi - 1) sok = 1'b0;
  endtask

  task automatic load_idle(input int p, input int l, input int h);
    run = 1'b0;
    psc_in = PSC_W'(p); low_in = CNT_W'(l); high_in = CNT_W'(h);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int lo, hi, guard;
    bit sok;
    string rq;

    // Reset state (R1)
    @(negedge clk);
    check(!scl_en && scl_level && !end_low && !end_high, "R1 reset idle",
          {scl_en, scl_level, end_low, end_high}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!scl_en && scl_level && !end_low && !end_high, "R1 idle after reset",
          {scl_en, scl_level, end_low, end_high}, 4'b0100);

    // Vector table: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      int p, l, h;
      p = int'(VEC[i][PSC_W+2*CNT_W-1 -: PSC_W]);
      l = int'(VEC[i][2*CNT_W-1 -: CNT_W]);
      h = int'(VEC[i][CNT_W-1:0]);
      load_idle(p, l, h);
      run = 1'b1;
      @(negedge clk);
      check(scl_en && !scl_level, "R2 low first", {scl_en, scl_level}, 2'b10);
      measure(lo, hi, sok);
      rq = (l == 0) ? "R5 R4 low length" : "R2 R4 low length";
      check(lo == exp_cycles(p, l), rq, lo, exp_cycles(p, l));
      rq = (h == 0) ? "R5 R4 high length" : "R3 R4 high length";
      check(hi == exp_cycles(p, h), rq, hi, exp_cycles(p, h));
      check(sok, "R6 strobe placement", int'(sok), 1);
      // R3: next phase is low again with the same length
      check(scl_en && !scl_level, "R3 alternation", {scl_en, scl_level}, 2'b10);
      check(int'(range_ok) == exp_range(p), "R9 range", int'(range_ok), exp_range(p));
    end

    // R7: inputs changed in the first running cycle are ignored
    load_idle(1, 5, 3);
    run = 1'b1;
    @(negedge clk);
    psc_in = 8'd0; low_in = 16'd40; high_in = 16'd40;
    measure(lo, hi, sok);
    check(lo == exp_cycles(1, 5), "R7 low kept", lo, exp_cycles(1, 5));
    check(hi == exp_cycles(1, 3), "R7 high kept", hi, exp_cycles(1, 3));
    measure(lo, hi, sok);
    check(lo == exp_cycles(1, 5), "R7 later low kept", lo, exp_cycles(1, 5));

    // R8: restart uses values captured during idle
    run = 1'b0;
    @(negedge clk);
    check(!scl_en && scl_level, "R8 idle after drop", {scl_en, scl_level}, 2'b01);
    run = 1'b1;
    @(negedge clk);
    measure(lo, hi, sok);
    check(lo == exp_cycles(0, 40), "R8 restart low", lo, exp_cycles(0, 40));
    check(hi == exp_cycles(0, 40), "R8 restart high", hi, exp_cycles(0, 40));

    // R8/R1: run dropped in the same cycle as end_low
    load_idle(0, 0, 0);
    run = 1'b1;
    @(negedge clk);
    guard = 0;
    while (!end_low && guard < 100) begin
      guard++;
      @(negedge clk);
    end
    check(end_low, "R6 strobe seen", int'(end_low), 1);
    run = 1'b0;
    @(negedge clk);
    check(!scl_en && scl_level && !end_low && !end_high, "R1 R8 drop on strobe",
          {scl_en, scl_level, end_low, end_high}, 4'b0100);
    run = 1'b1;
    @(negedge clk);
    check(scl_en && !scl_level, "R8 fresh low", {scl_en, scl_level}, 2'b10);
    measure(lo, hi, sok);
    check(lo == 7, "R8 R5 full low after drop", lo, 7);
    check(sok, "R6 strobes after restart", int'(sok), 1);

    run = 1'b0;
    @(negedge clk);
    report();
  end

endmodule